// File: doc/BRIEF.md
# Raster Sync and Blanking Generator

This block produces the timing skeleton of a raster video stream: horizontal and vertical sync, a data-enable that marks visible pixels, the current column and line numbers, and a one-pixel frame-start marker. It does not touch pixel data. A downstream fetch unit uses the column, line and data-enable outputs to supply pixels, and an encoder or DAC stage consumes the sync levels.

All geometry arrives as two packed 32-bit words, one per axis. Each word has a fixed field layout with a sync-polarity bit in bit 31. A separate byte gives the ratio between the system clock and the pixel rate. The block divides the system clock by that ratio into a pixel-enable strobe, and every counter advances only on that strobe. The configuration is captured during reset. After that it is re-captured only on the pixel-enable that ends a frame, so that software can rewrite the words at any time without tearing the current frame.

Top module: `vid_timing_gen`

## Requirements
- R1: `pix_en` is high for one system clock in every D clocks, where D is the `cfg_div` value. Values 0 and 1 both mean every clock. After reset the first strobe comes on clock D-1. D = 10 is supported.
- R2: `col` counts from 0 to HT-1 and then wraps to 0, stepping only on `pix_en`. HT = 8*A + HF + HS + HB, where A = `cfg_h`[7:0], HF = `cfg_h`[30:24], HS = `cfg_h`[23:16] and HB = `cfg_h`[15:8].
- R3: `line` steps by one on the `pix_en` that wraps `col`, and wraps to 0 after VT-1. VT = VA + VF + VS + VB, where VA = `cfg_v`[10:0], VF = `cfg_v`[30:23], VS = `cfg_v`[22:20] and VB = `cfg_v`[19:11].
- R4: Within a line the columns run in this order: visible (0 to 8A-1), front porch (HF columns), sync (HS columns), back porch (HB columns). Horizontal sync is asserted exactly on the sync columns.
- R5: Within a frame the lines run in the same order: visible (0 to VA-1), front porch (VF), sync (VS), back porch (VB). Vertical sync is asserted exactly on the sync lines.
- R6: Bit 31 of each axis word sets the active level of that axis's sync. When the bit is 1, sync is high while asserted and low otherwise. When the bit is 0, the levels are inverted.
- R7: `de` is high exactly when the column is below 8A and the line is below VA.
- R8: `frame_start` is high only on a clock where `pix_en` is high, `col` is 0 and `line` is 0.
- R9: The configuration inputs are sampled during reset and again on the `pix_en` that ends the last pixel of a frame. A change at any other time has no effect on the current frame. The new values, including a new divisor, govern the frame that follows.
- R10: The mode with 100 columns of eight pixels and horizontal porches 40/48/40 gives a line of 928 pixels. The mode with 480 lines and vertical porches 13/3/29 gives a frame of 525 lines.
- R11: While reset is held, `col` and `line` are 0 and both syncs are at their inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; captures the configuration |
| cfg_h | input | 32 | Horizontal word: polarity, front porch, sync, back porch, width/8 |
| cfg_v | input | 32 | Vertical word: polarity, front porch, sync, back porch, visible lines |
| cfg_div | input | 8 | System-clock-to-pixel ratio (byte 1 of the clock word) |
| pix_en | output | 1 | One-clock pixel strobe |
| hsync | output | 1 | Horizontal sync at the configured polarity |
| vsync | output | 1 | Vertical sync at the configured polarity |
| de | output | 1 | Visible-pixel marker |
| col | output | CW | Current column |
| line | output | CW | Current line |
| frame_start | output | 1 | High on the pixel strobe of column 0, line 0 |

## Verification
The bench builds the block with the default 12-bit counters. It runs mostly tiny geometries of 5 to 20 columns and 3 to 8 lines, so that several complete frames fit in a few thousand clocks. It compares every output on every clock against a closed-form model of pixel index, column and line, across divisors 0, 1, 2, 3 and 10 and all four polarity pairings. Because the frames are short, frame wrap-around, a configuration rewritten mid-frame with its deferred divisor change, and the 928-pixel and 525-line totals (each paired with a minimal other axis) all fit within the run.

// File: rtl/vid_timing_gen.sv
module vid_timing_gen #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   cfg_h,
  input  logic [31:0]   cfg_v,
  input  logic [7:0]    cfg_div,
  output logic          pix_en,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [CW-1:0] col,
  output logic [CW-1:0] line,
  output logic          frame_start
);

  logic [31:0]   sh_h, sh_v;
  logic [7:0]    sh_d, dcnt;
  logic [CW-1:0] hcnt, vcnt;
  logic          armed;

  wire [CW-1:0] h_act = CW'({sh_h[7:0], 3'b000});
  wire [CW-1:0] h_s0  = h_act + CW'(sh_h[30:24]);
  wire [CW-1:0] h_s1  = h_s0  + CW'(sh_h[23:16]);
  wire [CW-1:0] h_tot = h_s1  + CW'(sh_h[15:8]);

  wire [CW-1:0] v_act = CW'(sh_v[10:0]);
  wire [CW-1:0] v_s0  = v_act + CW'(sh_v[30:23]);
  wire [CW-1:0] v_s1  = v_s0  + CW'(sh_v[22:20]);
  wire [CW-1:0] v_tot = v_s1  + CW'(sh_v[19:11]);

  wire [7:0] dlim  = (sh_d > 8'd1) ? sh_d - 8'd1 : 8'd0;
  wire       h_end = hcnt == h_tot - CW'(1);
  wire       v_end = vcnt == v_tot - CW'(1);
  wire       f_end = pix_en && h_end && v_end;
  wire       hs_on = (hcnt >= h_s0) && (hcnt < h_s1);
  wire       vs_on = (vcnt >= v_s0) && (vcnt < v_s1);

  assign pix_en      = dcnt == dlim;
  assign hsync       = sh_h[31] ? hs_on : !hs_on;
  assign vsync       = sh_v[31] ? vs_on : !vs_on;
  assign de          = (hcnt < h_act) && (vcnt < v_act);
  assign col         = hcnt;
  assign line        = vcnt;
  assign frame_start = pix_en && hcnt == '0 && vcnt == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_h  <= cfg_h;
      sh_v  <= cfg_v;
      sh_d  <= cfg_div;
      dcnt  <= '0;
      hcnt  <= '0;
      vcnt  <= '0;
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
      dcnt  <= pix_en ? 8'd0 : dcnt + 8'd1;
      if (pix_en) begin
        if (h_end) begin
          hcnt <= '0;
          vcnt <= v_end ? '0 : vcnt + CW'(1);
        end else begin
          hcnt <= hcnt + CW'(1);
        end
      end
      if (f_end) begin
        sh_h <= cfg_h;
        sh_v <= cfg_v;
        sh_d <= cfg_div;
      end
    end
  end

  p_col_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> hcnt < h_tot);

  p_hold_between_strobes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !pix_en |=> $stable(hcnt) && $stable(vcnt));

  p_line_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && pix_en && h_end && !v_end |=> vcnt == CW'($past(vcnt) + CW'(1)));

  p_de_outside_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> !hs_on && !vs_on);

  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !f_end |=> $stable(sh_h) && $stable(sh_v) && $stable(sh_d));

  p_fs_on_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> pix_en && de == (h_act != '0 && v_act != '0));

endmodule

// File: tb/test_vid_timing_gen.sv
module test_vid_timing_gen;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   cfg_h = '0, cfg_v = '0;
  logic [7:0]    cfg_div = '0;
  logic          pix_en, hsync, vsync, de, frame_start;
  logic [CW-1:0] col, line;

  int checks = 0, errors = 0, maxcol = 0, maxline = 0;

  always #2 clk = ~clk;

  vid_timing_gen #(.CW(CW)) i_vid_timing_gen (
    .clk(clk), .rst_n(rst_n), .cfg_h(cfg_h), .cfg_v(cfg_v), .cfg_div(cfg_div),
    .pix_en(pix_en), .hsync(hsync), .vsync(vsync), .de(de),
    .col(col), .line(line), .frame_start(frame_start));

  function automatic logic [31:0] hw(int pol, int fp, int sw, int bp, int a8);
    return {pol[0], fp[6:0], sw[7:0], bp[7:0], a8[7:0]};
  endfunction

  function automatic logic [31:0] vw(int pol, int fp, int sw, int bp, int vis);
    return {pol[0], fp[7:0], sw[2:0], bp[8:0], vis[10:0]};
  endfunction

  function automatic int htot(logic [31:0] h);
    return 8 * int'(h[7:0]) + int'(h[30:24]) + int'(h[23:16]) + int'(h[15:8]);
  endfunction

  function automatic int vtot(logic [31:0] v);
    return int'(v[10:0]) + int'(v[30:23]) + int'(v[22:20]) + int'(v[19:11]);
  endfunction

  function automatic int dval(logic [7:0] d);
    return (d <= 8'd1) ? 1 : int'(d);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      if (errors < 30) $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare(logic [31:0] h, logic [31:0] v, logic [7:0] d, longint t);
    int dd = dval(d);
    longint p = t / dd;
    int ht = htot(h), vt = vtot(v);
    int c = int'(p % ht);
    int l = int'((p / ht) % vt);
    int ha = 8 * int'(h[7:0]);
    int hs0 = ha + int'(h[30:24]);
    int hs1 = hs0 + int'(h[23:16]);
    int va = int'(v[10:0]);
    int vs0 = va + int'(v[30:23]);
    int vs1 = vs0 + int'(v[22:20]);
    int pe = (t % dd) == dd - 1;
    int hon = c >= hs0 && c < hs1;
    int von = l >= vs0 && l < vs1;
    if (c > maxcol) maxcol = c;
    if (l > maxline) maxline = l;
    chk("R1 pix_en", int'(pix_en), pe);
    chk("R2 col", int'(col), c);
    chk("R3 line", int'(line), l);
    chk("R4/R6 hsync", int'(hsync), h[31] ? hon : !hon);
    chk("R5/R6 vsync", int'(vsync), v[31] ? von : !von);
    chk("R7 de", int'(de), (c < ha && l < va) ? 1 : 0);
    chk("R8 frame_start", int'(frame_start), (pe && c == 0 && l == 0) ? 1 : 0);
  endtask

  task automatic do_reset(logic [31:0] h, logic [31:0] v, logic [7:0] d);
    @(negedge clk);
    rst_n = 1'b0; cfg_h = h; cfg_v = v; cfg_div = d;
    @(negedge clk);
    @(negedge clk);
    chk("R11 reset col", int'(col), 0);
    chk("R11 reset line", int'(line), 0);
    chk("R11 reset hsync idle", int'(hsync), h[31] ? 0 : 1);
    chk("R11 reset vsync idle", int'(vsync), v[31] ? 0 : 1);
    rst_n = 1'b1;
    maxcol = 0; maxline = 0;
  endtask

  task automatic run(logic [31:0] h, logic [31:0] v, logic [7:0] d, int frames_x2);
    longint n = longint'(htot(h)) * vtot(v) * dval(d) * frames_x2 / 2;
    do_reset(h, v, d);
    for (longint t = 0; t < n; t++) begin
      compare(h, v, d, t);
      @(negedge clk);
    end
  endtask

  task automatic run_change(logic [31:0] ha, logic [31:0] va, logic [7:0] da,
                            logic [31:0] hb, logic [31:0] vb, logic [7:0] db);
    longint fa = longint'(htot(ha)) * vtot(va) * dval(da);
    longint fb = longint'(htot(hb)) * vtot(vb) * dval(db);
    do_reset(ha, va, da);
    for (longint t = 0; t < fa + fb + fb / 2; t++) begin
      if (t < fa) compare(ha, va, da, t);
      else        compare(hb, vb, db, t - fa);
      if (t == fa / 3) begin
        cfg_h = hb; cfg_v = vb; cfg_div = db;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    logic [31:0] h1, v1, h2, v2;
    logic [7:0] divs [5] = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd10};
    for (int pol = 0; pol < 4; pol++) begin
      h1 = hw(pol & 1, 2, 3, 1, 1);
      v1 = vw(pol >> 1, 1, 2, 2, 3);
      for (int k = 0; k < 5; k++) run(h1, v1, divs[k], 5);
    end
    h2 = hw(0, 1, 1, 2, 2);
    v2 = vw(1, 2, 1, 1, 2);
    for (int k = 0; k < 5; k++) run(h2, v2, divs[k], 4);
    // R9: mid-frame rewrite, including divisor, deferred to next frame
    run_change(h1, v1, 8'd2, h2, v2, 8'd3);
    run_change(h2, v2, 8'd1, h1, vw(0, 1, 2, 2, 3), 8'd10);
    // R10: 800-wide line with 40/48/40 horizontal porches
    run(hw(1, 40, 48, 40, 100), vw(1, 1, 1, 1, 2), 8'd1, 3);
    chk("R10 line total 928", maxcol + 1, 928);
    // R10: 480-line frame with 13/3/29 vertical porches
    run(hw(1, 1, 1, 1, 1), vw(1, 13, 3, 29, 480), 8'd1, 3);
    chk("R10 frame total 525", maxline + 1, 525);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule